// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block turns single-word requests into strobe sequences for a DRAM array whose row and column addresses share one set of address pins. A 20-bit word address is split into a 10-bit row and a 10-bit column. The row goes out first and is qualified by an active-low row strobe, which opens a whole row. The column then goes out on the same pins and is qualified by an active-low column strobe, which selects one word of the open row. The row stays open after the access. A later request to the same row skips the row phase (page mode). A request to a different row first closes the open row (precharge).

The block also refreshes the array on its own. After a programmable number of cycles it runs a row-strobe-only cycle on the next row from an internal counter, and the counter walks every row in turn. A pending refresh holds the request port not-ready but never breaks into an access that has already started. Access latency therefore varies, and the requester waits on a valid/ready handshake. Each accepted request is answered by a one-cycle response pulse, which carries read data for reads.

Top module: `dram_mux_ctrl`

## Requirements
- R1: During and right after reset, dram_ras_no, dram_cas_no and dram_we_no are 1, rsp_valid_o is 0 and req_ready_o is 1.
- R2: A request's row req_addr_i[19:10] is on dram_addr_o when dram_ras_no falls. Its column req_addr_i[9:0] is on the same pins when dram_cas_no falls.
- R3: dram_addr_o holds, in the cycle before each falling edge of either strobe, the same value it has in the cycle of that edge.
- R4: A read returns on rsp_rdata_o the word most recently written to the same address (row, column). A write stores req_wdata_i there, with dram_we_no low while dram_cas_no is low.
- R5: Counting cycles from the accepting clock edge to the first cycle in which rsp_valid_o is seen high, an access with no row open takes 5 cycles. An access to the open row takes 3 cycles and shows no falling edge on dram_ras_no.
- R6: An access to a row other than the open one raises dram_ras_no for at least two cycles before reopening, and takes 6 cycles.
- R7: rsp_valid_o is high for exactly one cycle per accepted request.
- R8: Refresh is a row-strobe cycle without a column strobe. Refreshed rows follow 0, 1, 2, ... 1023, 0 in order, one every REF_INTERVAL cycles on average.
- R9: A refresh never changes the latency of an accepted access given in R5 and R6. While a refresh is due or running, requests wait with req_ready_o low.
- R10: dram_cas_no is low only while dram_ras_no is low, and for one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Word address, row in upper 10 bits |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Read data, valid with rsp_valid_o |
| dram_addr_o | output | 10 | Shared row/column address pins |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_wdata_o | output | 8 | Data to array |
| dram_rdata_i | input | 8 | Data from array |

## Verification
A refresh falling due and a new request arriving can land in the same cycle. So can a refresh falling due and an access already in flight. The bench shortens the refresh interval and sends random traffic with random idle gaps, so both collisions happen many times. It checks that every accepted access keeps its exact latency. It also checks that the refresh row sequence seen on the pins stays gap-free and in order.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RSET, ST_RACT, ST_CSET, ST_CACT,
    ST_OPEN, ST_PRE, ST_FSET, ST_FACT, ST_FREL
  } seq_st_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 256,
  parameter int ROW_W    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)        pend_o <= 1'b1;
      else if (done_i) pend_o <= 1'b0;
      if (done_i)      row_o  <= row_o + 1'b1;
    end
  end
endmodule

// File: rtl/dram_row_track.sv
module dram_row_track #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] load_row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             hit_o
);
  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_row_q <= '0;
    else if (load_i) open_row_q <= load_row_i;
  end

  assign hit_o = (open_row_q == cmp_row_i);
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DATA_W = 8,
  localparam int A_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              row_hit_i,
  input  logic              ref_pend_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  output logic              req_ready_o,
  output logic              row_load_o,
  output logic [ROW_W-1:0]  row_sel_o,
  output logic              ref_done_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [A_W-1:0]    dram_addr_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i
);
  seq_st_e           st_q, st_d;
  logic              held_q, we_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;

  assign req_ready_o = ((st_q == ST_IDLE) || (st_q == ST_OPEN)) && !ref_pend_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_RSET;
               else if (ref_pend_i) st_d = ST_FSET;
      ST_OPEN: if (accept) st_d = row_hit_i ? ST_CSET : ST_PRE;
               else if (ref_pend_i) st_d = ST_PRE;
      ST_PRE:  st_d = held_q ? ST_RSET : ST_FSET;
      ST_RSET: st_d = ST_RACT;
      ST_RACT: st_d = ST_CSET;
      ST_CSET: st_d = ST_CACT;
      ST_CACT: st_d = ST_OPEN;
      ST_FSET: st_d = ST_FACT;
      ST_FACT: st_d = ST_FREL;
      ST_FREL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      held_q      <= 1'b0;
      we_q        <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      wdata_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_o <= (st_q == ST_CACT);
      if (accept) begin
        held_q  <= 1'b1;
        we_q    <= req_we_i;
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        wdata_q <= req_wdata_i;
      end else if (st_q == ST_CACT) begin
        held_q <= 1'b0;
      end
      if (st_q == ST_CACT && !we_q) rsp_rdata_o <= rdata_i;
    end
  end

  assign row_load_o = (st_q == ST_RACT);
  assign row_sel_o  = row_q;
  assign ref_done_o = (st_q == ST_FREL);

  // strobes decoded from the state flops
  always_comb begin
    ras_no = 1'b1;
    unique case (st_q)
      ST_RACT, ST_CSET, ST_CACT, ST_OPEN, ST_FACT: ras_no = 1'b0;
      default: ras_no = 1'b1;
    endcase
  end

  assign cas_no  = (st_q != ST_CACT);
  assign we_no   = !(we_q && ((st_q == ST_CSET) || (st_q == ST_CACT)));
  assign wdata_o = wdata_q;

  always_comb begin
    unique case (st_q)
      ST_RSET, ST_RACT: dram_addr_o = A_W'(row_q);
      ST_CSET, ST_CACT: dram_addr_o = A_W'(col_q);
      ST_FSET, ST_FACT: dram_addr_o = A_W'(ref_row_i);
      default:          dram_addr_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 8,
  parameter int REF_INTERVAL = 256,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int A_W         = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [A_W-1:0]    dram_addr_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic [DATA_W-1:0] dram_wdata_o,
  input  logic [DATA_W-1:0] dram_rdata_i
);
  logic [ROW_W-1:0] req_row, ref_row, row_sel;
  logic [COL_W-1:0] req_col;
  logic             row_hit, row_load, ref_pend, ref_done;

  assign req_row = req_addr_i[ADDR_W-1:COL_W];
  assign req_col = req_addr_i[COL_W-1:0];

  dram_refresh_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_ref (
    .clk_i, .rst_ni, .done_i(ref_done), .pend_o(ref_pend), .row_o(ref_row)
  );

  dram_row_track #(.ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni, .load_i(row_load), .load_row_i(row_sel),
    .cmp_row_i(req_row), .hit_o(row_hit)
  );

  dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_we_i,
    .req_row_i(req_row), .req_col_i(req_col), .req_wdata_i,
    .row_hit_i(row_hit), .ref_pend_i(ref_pend), .ref_row_i(ref_row),
    .req_ready_o, .row_load_o(row_load), .row_sel_o(row_sel),
    .ref_done_o(ref_done), .rsp_valid_o, .rsp_rdata_o,
    .dram_addr_o, .ras_no(dram_ras_no), .cas_no(dram_cas_no),
    .we_no(dram_we_no), .wdata_o(dram_wdata_o), .rdata_i(dram_rdata_i)
  );
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int A_W = 10
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic           rsp_valid_o,
  input logic [A_W-1:0] dram_addr_o,
  input logic           dram_ras_no,
  input logic           dram_cas_no
);
  a_r10_cas_inside_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  a_r10_cas_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |=> dram_cas_no);
  a_r3_row_addr_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> $stable(dram_addr_o));
  a_r3_col_addr_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> $stable(dram_addr_o));
  a_r7_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r5_no_instant_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !rsp_valid_o);
  a_r6_precharge_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |=> dram_ras_no);
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.A_W(A_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .dram_addr_o(dram_addr_o), .dram_ras_no(dram_ras_no),
  .dram_cas_no(dram_cas_no)
);

// File: tb/sim_dram_mux_ctrl.sv
module sim_dram_mux_ctrl;
  localparam int REF_IV = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [9:0]  dram_addr;
  logic        ras_n, cas_n, we_n;
  logic [7:0]  dram_wdata;
  logic [7:0]  dram_rdata = '0;

  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  dram_mux_ctrl #(.REF_INTERVAL(REF_IV)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_addr_o(dram_addr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_wdata_o(dram_wdata), .dram_rdata_i(dram_rdata)
  );

  function automatic logic [7:0] init_word(int k);
    return 8'((k * 37) ^ (k >> 9) ^ 8'h5a);
  endfunction

  // behavioural array, driven only from the pins
  logic [7:0] arr [int];
  logic [9:0] arr_row = '0;
  logic       arr_ras_q = 1'b1;
  always @(posedge clk) begin
    if (!ras_n && arr_ras_q) arr_row <= dram_addr;
    if (!cas_n && !we_n) arr[{arr_row, dram_addr}] = dram_wdata;
    arr_ras_q <= ras_n;
  end
  always @(negedge clk) begin
    int k;
    k = {arr_row, dram_addr};
    dram_rdata <= arr.exists(k) ? arr[k] : init_word(k);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // bench-side expectation
  logic [7:0] gold [int];
  bit         busy = 0, open_valid = 0;
  logic [9:0] open_row = '0, cur_row = '0, cur_col = '0;
  int         ras_falls_busy = 0, exp_ref = 0, ref_cnt = 0;

  // pin monitor
  logic       mon_ras_q = 1'b1, mon_cas_q = 1'b1;
  logic [9:0] mon_addr_q = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (mon_ras_q && !ras_n) begin
        chk(mon_addr_q == dram_addr, "R3 row setup", int'(dram_addr), int'(mon_addr_q));
        if (busy) begin
          ras_falls_busy++;
          chk(dram_addr == cur_row, "R2 row addr", int'(dram_addr), int'(cur_row));
        end else begin
          chk(int'(dram_addr) == exp_ref, "R8 refresh row", int'(dram_addr), exp_ref);
          exp_ref    = (exp_ref + 1) % 1024;
          ref_cnt++;
          open_valid = 0;
        end
      end
      if (mon_cas_q && !cas_n) begin
        chk(mon_addr_q == dram_addr, "R3 col setup", int'(dram_addr), int'(mon_addr_q));
        chk(busy && dram_addr == cur_col, "R2 col addr", int'(dram_addr), int'(cur_col));
      end
      if (!cas_n) begin
        chk(!ras_n, "R10 cas inside row", int'(ras_n), 0);
        chk(mon_cas_q, "R10 cas one cycle", int'(mon_cas_q), 1);
      end
      mon_ras_q  = ras_n;
      mon_cas_q  = cas_n;
      mon_addr_q = dram_addr;
    end
  end

  task automatic do_req(input bit we, input logic [19:0] a, input logic [7:0] wd);
    int lat, exp_lat, ex;
    logic [9:0] r;
    r = a[19:10];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_lat = !open_valid ? 5 : (open_row == r ? 3 : 6);
    busy = 1; cur_row = r; cur_col = a[9:0]; ras_falls_busy = 0;
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    // R9: latency unchanged whatever refresh does
    chk(lat == exp_lat, "R5/R6/R9 latency", lat, exp_lat);
    if (exp_lat == 3)
      chk(ras_falls_busy == 0, "R5 page hit no row strobe", ras_falls_busy, 0);
    if (exp_lat == 6)
      chk(ras_falls_busy == 1, "R6 reopen once", ras_falls_busy, 1);
    if (!we) begin
      ex = gold.exists(int'(a)) ? int'(gold[int'(a)]) : int'(init_word(int'(a)));
      chk(int'(rsp_rdata) == ex, "R4 read data", int'(rsp_rdata), ex);
    end else begin
      gold[int'(a)] = wd;
    end
    open_valid = 1; open_row = r; busy = 0;
    @(negedge clk);
    chk(!rsp_valid, "R7 response pulse", int'(rsp_valid), 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int seed, c0, c1, exp_n;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", int'({ras_n, cas_n, we_n}), 7);
    chk(!rsp_valid, "R1 rsp low in reset", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle after reset", int'({ras_n, cas_n, we_n}), 7);
    chk(req_ready && !rsp_valid, "R1 ready after reset", int'({req_ready, rsp_valid}), 2);

    // directed corners
    do_req(1, {10'd5, 10'd7}, 8'hc3);
    do_req(0, {10'd5, 10'd7}, 8'h00);          // R4 write then read, R5 hit
    do_req(0, {10'd5, 10'd8}, 8'h00);
    do_req(0, {10'd9, 10'd8}, 8'h00);          // R6 row change
    do_req(1, {10'd1023, 10'd1023}, 8'h81);
    do_req(0, {10'd1023, 10'd1023}, 8'h00);
    do_req(1, {10'd0, 10'd0}, 8'h18);
    do_req(0, {10'd0, 10'd0}, 8'h00);
    do_req(0, {10'd1023, 10'd1023}, 8'h00);

    // random traffic with gaps that collide with refresh (R9)
    for (int i = 0; i < 400; i++) begin
      logic [9:0] r, c;
      r = ($urandom % 4 == 0) ? 10'($urandom) : 10'($urandom % 4);
      c = ($urandom % 2 == 0) ? 10'($urandom % 8) : 10'($urandom);
      do_req(1'($urandom % 3 == 0), {r, c}, 8'($urandom));
      repeat ($urandom % 12) @(negedge clk);
    end

    // long idle: refresh walks and wraps all rows (R8)
    c0 = cyc;
    repeat (1024 * REF_IV + 200) @(negedge clk);
    c1 = cyc;
    chk(exp_ref != 0 || ref_cnt >= 1024, "R8 wrap", ref_cnt, 1024);
    exp_n = c1 / REF_IV;
    chk(ref_cnt >= exp_n - 2 && ref_cnt <= exp_n + 1, "R8 refresh rate", ref_cnt, exp_n);
    chk(c1 - c0 > 0, "R8 idle window", c1 - c0, 1024 * REF_IV);
    do_req(0, {10'd5, 10'd7}, 8'h00);
    finish_run();
  end
endmodule